// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block generates one pulse-width-modulated output from a programmable counter. A counting tick is taken either from the base clock divided by a power of two or from one of two external tick enables. On each tick the counter advances in left-aligned mode (a sawtooth from zero) or center-aligned mode (a triangle up to the period value and back). While the counter is below the duty value the output sits at its active level. For the rest of the period it sits at its programmable idle level.

Software sets the clock source, alignment, polarity, period and duty while the channel is disabled, then raises the enable input. While the channel runs, the only way to change it is a single update register. A value written there is held and copied into either the period or the duty register, as chosen by a mode bit, at the next period boundary. A sticky event flag, mirrored on an interrupt output, tells software that a boundary has passed and any pending value has been applied.

Top module: `pwm_chan_top`

## Requirements
- R1: The register offsets are: mode 0x00, duty 0x04, period 0x08, counter 0x0C, update 0x10 and status 0x14. All read back their contents on `busRdata`. Writes to the counter have no effect. Status bit 0 is the event flag and status bit 1 is set while an update value is pending. All registers reset to zero.
- R2: Mode bits [3:0] select the tick. A value k from 0 to 10 gives one tick every 2^k base clocks, with the first tick 2^k clocks after enable. 0xB counts `tickA` pulses, 0xC counts `tickB` pulses, and 0xD to 0xF give no ticks.
- R3: With mode bit 8 clear (left-aligned), the counter steps 0,1,...,P-1 and then returns to 0, where P is the period value. A period of 0 behaves as 1.
- R4: With mode bit 8 set (center-aligned), the counter steps from 0 up to P and back down to 0, so one period is 2P ticks. A period of 0 behaves as 1.
- R5: While running, the output is at its active level when counter < duty and at its idle level otherwise. Mode bit 9 set means idle high and active low. Mode bit 9 clear means idle low and active high.
- R6: While `chanEn` is low, the counter and prescaler are held at zero and the output is at the idle level.
- R7: Writes to mode, duty and period are ignored while `chanEn` is high.
- R8: A write to the update register is held and copied at the next period boundary (the tick that returns the counter to 0). It goes into the period when mode bit 10 is set and into the duty when bit 10 is clear. It is never copied mid-period.
- R9: Each period boundary sets the event flag, which drives `irqOut`. A read of status (`busRd` with address 0x14) clears the flag unless a boundary occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanEn | input | 1 | Channel run enable |
| tickA | input | 1 | External tick enable A |
| tickB | input | 1 | External tick enable B |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (clears flag on status read) |
| busAddr | input | 5 | Register byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| pwmOut | output | 1 | PWM waveform |
| irqOut | output | 1 | Per-period event interrupt |

## Verification
A wrong counter direction or wrap point shows up on the counter read port and on `pwmOut` within one period of the configured length, so short periods are swept exhaustively with every duty from zero to the period. A double-buffer fault would either change the duty or period read-back mid-period or fail to change it on the boundary tick. External tick pulses are stepped one at a time so each boundary can be checked to the exact cycle. A stuck event flag appears immediately on `irqOut` after a status read.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  // register byte offsets
  localparam int OFS_MODE   = 'h00;
  localparam int OFS_DUTY   = 'h04;
  localparam int OFS_PERIOD = 'h08;
  localparam int OFS_COUNT  = 'h0C;
  localparam int OFS_UPDATE = 'h10;
  localparam int OFS_STATUS = 'h14;

  // mode register fields
  localparam int SEL_W          = 4;
  localparam int MAX_POW        = 10;
  localparam int BIT_CENTER     = 8;
  localparam int BIT_IDLE_HIGH  = 9;
  localparam int BIT_UPD_PERIOD = 10;
  localparam logic [SEL_W-1:0] SEL_EXT_A = 4'hB;
  localparam logic [SEL_W-1:0] SEL_EXT_B = 4'hC;

  // control-to-datapath strobes
  typedef struct packed {
    logic run;
    logic center;
    logic idleHigh;
  } chanStrobe_t;
endpackage

// File: rtl/pwm_chan_presc.sv
module pwm_chan_presc
  import pwm_chan_pkg::*;
#(
  parameter int MAXP = MAX_POW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             extA,
  input  logic             extB,
  output logic             tick
);
  localparam int DIV_W = MAXP;

  logic [DIV_W-1:0] divCnt;
  logic [MAXP:0]    powTick;
  logic             selTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      divCnt <= '0;
    else if (!run)  divCnt <= '0;
    else            divCnt <= divCnt + 1'b1;
  end

  // one tick candidate per power-of-two division
  for (genvar k = 0; k <= MAXP; k++) begin : g_pow
    if (k == 0) begin : g_div1
      assign powTick[k] = 1'b1;
    end else begin : g_divn
      assign powTick[k] = &divCnt[k-1:0];
    end
  end

  always_comb begin
    selTick = 1'b0;
    for (int k = 0; k <= MAXP; k++) begin
      if (clkSel == SEL_W'(k)) selTick = powTick[k];
    end
    if (clkSel == SEL_EXT_A) selTick = extA;
    if (clkSel == SEL_EXT_B) selTick = extB;
  end

  assign tick = run & selTick;
endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strb,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             tickA,
  input  logic             tickB,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] dutyVal,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary,
  output logic             pwmOut
);
  logic           tick;
  logic           dirDown;
  logic [CNT_W:0] cntInc;
  logic [CNT_W:0] periodExt;
  logic           wrapLeft;
  logic           wrapCenter;

  pwm_chan_presc #(.MAXP(MAX_POW)) uPresc (
    .clk    (clk),
    .rstN   (rstN),
    .run    (strb.run),
    .clkSel (clkSel),
    .extA   (tickA),
    .extB   (tickB),
    .tick   (tick)
  );

  assign cntInc     = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign periodExt  = {1'b0, periodVal};
  assign wrapLeft   = (cntInc >= periodExt);
  assign wrapCenter = dirDown && (cnt <= CNT_W'(1));
  assign boundary   = tick && (strb.center ? wrapCenter : wrapLeft);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dirDown <= 1'b0;
    end else if (!strb.run) begin
      cnt     <= '0;
      dirDown <= 1'b0;
    end else if (tick) begin
      if (!strb.center) begin
        cnt <= wrapLeft ? '0 : cntInc[CNT_W-1:0];
      end else if (!dirDown) begin
        cnt <= cntInc[CNT_W-1:0];
        if (cntInc >= periodExt) dirDown <= 1'b1;
      end else if (wrapCenter) begin
        cnt     <= '0;
        dirDown <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    if (strb.run && (cnt < dutyVal)) pwmOut = ~strb.idleHigh;
    else                             pwmOut = strb.idleHigh;
  end

  // R6: a stopped channel returns its counter to zero
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (cnt == '0));

  // R3: left-aligned counter never reaches the period value
  p_left_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.center) |-> ((cnt < periodVal) || (cnt == '0)));

  // R4: center-aligned counter peaks at the period value
  p_center_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.center) |-> ((cnt <= periodVal) || (cnt == CNT_W'(1))));
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              boundary,
  output chanStrobe_t       strb,
  output logic [SEL_W-1:0]  clkSel,
  output logic [CNT_W-1:0]  periodVal,
  output logic [CNT_W-1:0]  dutyVal,
  output logic              irq
);
  logic [31:0]      addrExt;
  logic             hitMode, hitDuty, hitPeriod, hitCount, hitUpdate, hitStatus;
  logic             cfgWrOk;
  logic [SEL_W-1:0] modeSel;
  logic             modeCenter, modeIdleHigh, modeUpdPeriod;
  logic [CNT_W-1:0] periodReg, dutyReg, updReg;
  logic             updPending, evtFlag;
  logic             unusedWdata;

  assign addrExt   = 32'(busAddr);
  assign hitMode   = (addrExt == 32'(OFS_MODE));
  assign hitDuty   = (addrExt == 32'(OFS_DUTY));
  assign hitPeriod = (addrExt == 32'(OFS_PERIOD));
  assign hitCount  = (addrExt == 32'(OFS_COUNT));
  assign hitUpdate = (addrExt == 32'(OFS_UPDATE));
  assign hitStatus = (addrExt == 32'(OFS_STATUS));
  assign cfgWrOk   = busWr && !chanEn;
  assign unusedWdata = ^busWdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel       <= '0;
      modeCenter    <= 1'b0;
      modeIdleHigh  <= 1'b0;
      modeUpdPeriod <= 1'b0;
      periodReg     <= '0;
      dutyReg       <= '0;
      updReg        <= '0;
      updPending    <= 1'b0;
    end else begin
      if (cfgWrOk && hitMode) begin
        modeSel       <= busWdata[SEL_W-1:0];
        modeCenter    <= busWdata[BIT_CENTER];
        modeIdleHigh  <= busWdata[BIT_IDLE_HIGH];
        modeUpdPeriod <= busWdata[BIT_UPD_PERIOD];
      end
      if (cfgWrOk && hitPeriod) periodReg <= busWdata[CNT_W-1:0];
      if (cfgWrOk && hitDuty)   dutyReg   <= busWdata[CNT_W-1:0];
      // double buffer: apply at boundary, a same-cycle write stays pending
      if (boundary && updPending) begin
        if (modeUpdPeriod) periodReg <= updReg;
        else               dutyReg   <= updReg;
        updPending <= 1'b0;
      end
      if (busWr && hitUpdate) begin
        updReg     <= busWdata[CNT_W-1:0];
        updPending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        evtFlag <= 1'b0;
    else if (boundary)                evtFlag <= 1'b1;
    else if (busRd && hitStatus)      evtFlag <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    if (hitMode) begin
      busRdata[SEL_W-1:0]      = modeSel;
      busRdata[BIT_CENTER]     = modeCenter;
      busRdata[BIT_IDLE_HIGH]  = modeIdleHigh;
      busRdata[BIT_UPD_PERIOD] = modeUpdPeriod;
    end
    if (hitDuty)   busRdata = DATA_W'(dutyReg);
    if (hitPeriod) busRdata = DATA_W'(periodReg);
    if (hitCount)  busRdata = DATA_W'(cnt);
    if (hitUpdate) busRdata = DATA_W'(updReg);
    if (hitStatus) busRdata = DATA_W'({updPending, evtFlag});
  end

  assign strb.run      = chanEn;
  assign strb.center   = modeCenter;
  assign strb.idleHigh = modeIdleHigh;
  assign clkSel        = modeSel;
  assign periodVal     = periodReg;
  assign dutyVal       = dutyReg;
  assign irq           = evtFlag;

  // R8 and R7: a running channel keeps period and duty between boundaries
  p_hold_mid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !boundary) |=> ($stable(periodReg) && $stable(dutyReg)));

  // R8: pending period value lands on the boundary
  p_apply_period_r8: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && updPending && modeUpdPeriod && !(busWr && hitUpdate))
      |=> (periodReg == $past(updReg)));

  // R9: every boundary leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> irq);
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
  import pwm_chan_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              tickA,
  input  logic              tickB,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pwmOut,
  output logic              irqOut
);
  chanStrobe_t      strb;
  logic [SEL_W-1:0] clkSel;
  logic [CNT_W-1:0] periodVal, dutyVal, cnt;
  logic             boundary;

  pwm_chan_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanEn    (chanEn),
    .busWr     (busWr),
    .busRd     (busRd),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .cnt       (cnt),
    .boundary  (boundary),
    .strb      (strb),
    .clkSel    (clkSel),
    .periodVal (periodVal),
    .dutyVal   (dutyVal),
    .irq       (irqOut)
  );

  pwm_chan_dp #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .clkSel    (clkSel),
    .tickA     (tickA),
    .tickB     (tickB),
    .periodVal (periodVal),
    .dutyVal   (dutyVal),
    .cnt       (cnt),
    .boundary  (boundary),
    .pwmOut    (pwmOut)
  );
endmodule

// File: tb/sim_pwm_chan_top.sv
module sim_pwm_chan_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MODE = 5'h00, A_DUTY = 5'h04, A_PERIOD = 5'h08,
                         A_COUNT = 5'h0C, A_UPDATE = 5'h10, A_STATUS = 5'h14;

  logic        clk, rstN, chanEn, tickA, tickB, busWr, busRd;
  logic [4:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic        pwmOut, irqOut;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  pwm_chan_top u0 (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .tickA(tickA), .tickB(tickB),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pwmOut(pwmOut), .irqOut(irqOut)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    finishRun();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    step();
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic clrStatus();
    busAddr = A_STATUS; busRd = 1'b1;
    step();
    busRd = 1'b0;
  endtask

  task automatic pulseA();
    tickA = 1'b1;
    step();
    tickA = 1'b0;
  endtask

  task automatic pulseB();
    tickB = 1'b1;
    step();
    tickB = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    rstN = 0; chanEn = 0; tickA = 0; tickB = 0; busWr = 0; busRd = 0;
    busAddr = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    step();

    // reset state (R1, R6)
    rd(A_MODE, v);   chk("R1 reset mode", v, 0);
    rd(A_PERIOD, v); chk("R1 reset period", v, 0);
    rd(A_DUTY, v);   chk("R1 reset duty", v, 0);
    rd(A_COUNT, v);  chk("R1 reset count", v, 0);
    rd(A_STATUS, v); chk("R1 reset status", v, 0);
    chk("R6 reset output idle", 32'(pwmOut), 0);
    chk("R9 reset irq", 32'(irqOut), 0);

    // counter register is read-only (R1)
    wr(A_COUNT, 32'd5);
    rd(A_COUNT, v); chk("R1 count write ignored", v, 0);

    // sweep: alignment x period x duty x polarity (R3 R4 R5 R9 R6)
    for (int ctr = 0; ctr < 2; ctr++) begin
      for (int idl = 0; idl < 2; idl++) begin
        for (int p = 1; p <= 4; p++) begin
          for (int d = 0; d <= p; d++) begin
            int len;
            chanEn = 0;
            wr(A_MODE, 32'((ctr << 8) | (idl << 9)));
            wr(A_PERIOD, 32'(p));
            wr(A_DUTY, 32'(d));
            clrStatus();
            busAddr = A_COUNT;
            len = ctr ? 2 * p : p;
            chanEn = 1;
            for (int m = 1; m <= 2 * len + 1; m++) begin
              int ph, ec, eo;
              step();
              ph = m % len;
              if (ctr == 0) ec = ph;
              else ec = (ph <= p) ? ph : len - ph;
              eo = (ec < d) ? (1 - idl) : idl;
              if (ctr == 0) chk("R3 left count", busRdata, 32'(ec));
              else          chk("R4 center count", busRdata, 32'(ec));
              chk("R5 output level", 32'(pwmOut), 32'(eo));
            end
            chk("R9 irq after boundary", 32'(irqOut), 1);
            chanEn = 0;
            step();
            chk("R6 count cleared when off", busRdata, 0);
            chk("R6 output idle when off", 32'(pwmOut), 32'(idl));
          end
        end
      end
    end

    // period zero acts as one (R3)
    wr(A_MODE, 32'h0);
    wr(A_PERIOD, 32'h0);
    busAddr = A_COUNT;
    chanEn = 1;
    for (int m = 1; m <= 4; m++) begin
      step();
      chk("R3 period zero count", busRdata, 0);
    end
    chanEn = 0;
    step();

    // prescaler sweep (R2)
    wr(A_PERIOD, 32'd1000);
    wr(A_DUTY, 32'd0);
    for (int k = 0; k <= 4; k++) begin
      chanEn = 0;
      wr(A_MODE, 32'(k));
      busAddr = A_COUNT;
      chanEn = 1;
      for (int m = 1; m <= 40; m++) begin
        step();
        chk("R2 power-of-two divide", busRdata, 32'(m >> k));
      end
    end
    chanEn = 0;
    wr(A_MODE, 32'hD);
    busAddr = A_COUNT;
    chanEn = 1;
    for (int m = 1; m <= 10; m++) begin
      step();
      chk("R2 reserved select no ticks", busRdata, 0);
    end
    chanEn = 0;
    step();

    // external ticks (R2)
    wr(A_MODE, 32'hB);
    wr(A_PERIOD, 32'd8);
    busAddr = A_COUNT;
    chanEn = 1;
    for (int i = 1; i <= 5; i++) begin
      pulseA();
      chk("R2 tickA counts", busRdata, 32'(i));
      pulseB();
      chk("R2 tickB ignored on A", busRdata, 32'(i));
    end
    chanEn = 0;
    wr(A_MODE, 32'hC);
    busAddr = A_COUNT;
    chanEn = 1;
    for (int i = 1; i <= 3; i++) begin
      pulseB();
      chk("R2 tickB counts", busRdata, 32'(i));
      pulseA();
      chk("R2 tickA ignored on B", busRdata, 32'(i));
    end
    chanEn = 0;
    step();

    // double-buffered duty update (R7 R8 R9)
    wr(A_MODE, 32'hB);
    wr(A_PERIOD, 32'd4);
    wr(A_DUTY, 32'd1);
    clrStatus();
    chanEn = 1;
    pulseA();
    wr(A_UPDATE, 32'd3);
    rd(A_DUTY, v);   chk("R8 duty held mid-period", v, 1);
    chk("R8 output uses old duty", 32'(pwmOut), 0);
    wr(A_PERIOD, 32'd7);
    rd(A_PERIOD, v); chk("R7 period write ignored", v, 4);
    wr(A_DUTY, 32'd2);
    rd(A_DUTY, v);   chk("R7 duty write ignored", v, 1);
    wr(A_MODE, 32'h30B);
    rd(A_MODE, v);   chk("R7 mode write ignored", v, 32'hB);
    pulseA();
    pulseA();
    rd(A_DUTY, v);   chk("R8 duty held at count 3", v, 1);
    rd(A_STATUS, v); chk("R1 status pending only", v, 2);
    pulseA();
    rd(A_COUNT, v);  chk("R3 wrap on tick", v, 0);
    rd(A_DUTY, v);   chk("R8 duty applied at boundary", v, 3);
    rd(A_STATUS, v); chk("R9 flag set, pending cleared", v, 1);
    chk("R9 irq raised", 32'(irqOut), 1);
    chk("R5 active with new duty", 32'(pwmOut), 1);
    clrStatus();
    rd(A_STATUS, v); chk("R9 read clears flag", v, 0);
    chk("R9 irq cleared", 32'(irqOut), 0);
    pulseA(); chk("R5 new duty count1", 32'(pwmOut), 1);
    pulseA(); chk("R5 new duty count2", 32'(pwmOut), 1);
    pulseA(); chk("R5 new duty count3", 32'(pwmOut), 0);
    chanEn = 0;
    step();

    // double-buffered period update (R8)
    wr(A_MODE, 32'h40B);
    wr(A_DUTY, 32'd0);
    wr(A_PERIOD, 32'd4);
    chanEn = 1;
    pulseA();
    wr(A_UPDATE, 32'd2);
    pulseA();
    pulseA();
    rd(A_PERIOD, v); chk("R8 period held mid-period", v, 4);
    rd(A_DUTY, v);   chk("R8 duty untouched by period target", v, 0);
    pulseA();
    rd(A_PERIOD, v); chk("R8 period applied at boundary", v, 2);
    clrStatus();
    pulseA();
    rd(A_COUNT, v);  chk("R3 new period count1", v, 1);
    rd(A_STATUS, v); chk("R9 no flag mid-period", v, 0);
    pulseA();
    rd(A_COUNT, v);  chk("R3 new period wrap", v, 0);
    rd(A_STATUS, v); chk("R9 flag at new boundary", v, 1);
    chanEn = 0;
    step();

    finishRun();
  end
endmodule